// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of a receive path and decides whether an incoming frame is kept, based only on its 48-bit destination address. The address arrives one byte per cycle, first byte first, with a start marker on the first byte. Valid strobes may have idle cycles between them. While the bytes stream in, a serial CRC-32 is folded over them. After the sixth byte, the top six bits of that CRC pick one bin of a 64-bin multicast hash table.

The accept decision combines five sources:
- a programmed station address for unicast frames;
- a broadcast enable for the all-ones address;
- the hash table for other group addresses;
- an all-multicast mode;
- a promiscuous mode.

Software programs these through a small word-wide register port. By convention, software clears both hash words before it fills them.

The controller is a three-state machine:
- `ST_IDLE` waits for the first frame.
- `ST_COLLECT` gathers bytes 1 to 5.
- `ST_DONE` presents the held decision.

Its transitions are:
- start: any state to `ST_COLLECT` on a byte carrying the start marker.
- last byte: `ST_COLLECT` to `ST_DONE` on the sixth byte.
- hold: every other case keeps the current state.

Top module: `addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0 and every configuration register reads 0.
- R2: Registers are written when `cfg_we` is 1 and read combinationally on `cfg_rdata`. The register addresses are: 0 station low word, 1 station high word (bits 15:0 only; bits 31:16 read as 0), 2 mode, 3 hash lower word, 4 hash upper word. Mode bit 0 is promiscuous, bit 1 is all-multicast and bit 2 is broadcast enable. Mode bits 31:3 read as 0.
- R3: Destination byte k is the k-th byte received, counting from 0. The station address has byte 0 in high word bits 15:8, byte 1 in bits 7:0, and bytes 2 to 5 in low word bits 31:24, 23:16, 15:8 and 7:0. A frame whose first byte has bit 0 clear is accepted only when all six bytes equal the station address.
- R4: The address FF:FF:FF:FF:FF:FF is accepted exactly when broadcast enable or promiscuous mode is set. The hash table and all-multicast mode do not apply to it.
- R5: For any other address whose first byte has bit 0 set, the block runs a CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. For each bit, data LSB first within a byte, it computes `fb = crc[31] ^ bit`, shifts `crc` left by one, and XORs in the polynomial when `fb` is 1. There is no final inversion. The frame is accepted when bit `crc[30:26]` is set in the hash upper word (if `crc[31]` is 1) or in the hash lower word (if `crc[31]` is 0).
- R6: With all-multicast set, every group address other than broadcast is accepted, whatever the table holds.
- R7: With promiscuous set, every address is accepted.
- R8: `dec_valid` rises in the cycle after the clock edge that takes the sixth byte. Cycles with `rx_valid` low between bytes are skipped without effect.
- R9: The decision uses the configuration present at the sixth byte. It stays unchanged, even across register writes, until the next start byte. `dec_valid` drops in the cycle after a start byte, and a start byte in the middle of an address restarts collection.
- R10: A byte that arrives without the start marker while no address is being collected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_valid | input | 1 | `rx_byte` carries a byte this cycle |
| rx_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | Decision is available |
| dec_accept | output | 1 | Frame accepted (meaningful when `dec_valid` is 1) |

## Verification
The bench picks group addresses whose CRC bit 31 is 0 and others whose bit 31 is 1. A design that swapped the two table words, used the wrong five index bits or fed bits MSB-first would accept from the wrong bin. Broadcast is run with all-multicast on and broadcast enable off, which catches a design that lets the group path swallow the all-ones address. Bytes are sent with idle gaps and a restart in mid-address, which exposes a byte counter that advances on idle cycles or ignores a new start. Mode and table writes after the decision check that the result is latched and not recomputed live.

// File: rtl/afp_pkg.sv
package afp_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_DONE} afp_state_e;

    localparam int CFG_AW       = 3;
    localparam int CFG_DW       = 32;
    localparam int ADDR_BYTES   = 6;
    localparam int HASH_WORDS   = 2;
    localparam int HASH_BITS    = HASH_WORDS * CFG_DW;
    localparam int BIN_W        = $clog2(HASH_BITS);

    localparam logic [CFG_AW-1:0] RA_STA_LO  = 3'd0;
    localparam logic [CFG_AW-1:0] RA_STA_HI  = 3'd1;
    localparam logic [CFG_AW-1:0] RA_MODE    = 3'd2;
    localparam logic [CFG_AW-1:0] RA_HASH0   = 3'd3;

    localparam int MODE_PROMISC  = 0;
    localparam int MODE_ALLMULTI = 1;
    localparam int MODE_BCAST    = 2;
    localparam int MODE_W        = 3;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
endpackage

// File: rtl/afp_crc_be.sv
module afp_crc_be #(
    parameter int CW = 32,
    parameter logic [CW-1:0] POLY = 32'h04C11DB7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [7:0]    data,
    output logic [CW-1:0] crc_nxt
);
    logic [CW-1:0] crc_q;
    logic [CW-1:0] seed;

    always_comb begin
        logic [CW-1:0] c;
        logic          fb;
        seed = restart ? '1 : crc_q;
        c    = seed;
        for (int b = 0; b < 8; b++) begin
            fb = c[CW-1] ^ data[b];
            c  = {c[CW-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_nxt = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= '1;
        else if (step) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/afp_cfg_regs.sv
module afp_cfg_regs
    import afp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_AW-1:0]    addr,
    input  logic [CFG_DW-1:0]    wdata,
    output logic [CFG_DW-1:0]    rdata,
    output logic [47:0]          station,
    output logic [HASH_BITS-1:0] table_bits,
    output logic [MODE_W-1:0]    mode
);
    logic [CFG_DW-1:0] sta_lo_q;
    logic [15:0]       sta_hi_q;
    logic [MODE_W-1:0] mode_q;
    logic [CFG_DW-1:0] hash_q [HASH_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_lo_q <= '0;
            sta_hi_q <= '0;
            mode_q   <= '0;
        end else if (we) begin
            if (addr == RA_STA_LO) sta_lo_q <= wdata;
            if (addr == RA_STA_HI) sta_hi_q <= wdata[15:0];
            if (addr == RA_MODE)   mode_q   <= wdata[MODE_W-1:0];
        end
    end

    for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
        localparam logic [CFG_AW-1:0] MY_ADDR = RA_HASH0 + CFG_AW'(k);
        always_ff @(posedge clk) begin
            if (!rst_n)                        hash_q[k] <= '0;
            else if (we && addr == MY_ADDR)    hash_q[k] <= wdata;
        end
        assign table_bits[k*CFG_DW +: CFG_DW] = hash_q[k];
    end

    always_comb begin
        rdata = '0;
        if (addr == RA_STA_LO) rdata = sta_lo_q;
        if (addr == RA_STA_HI) rdata = {16'b0, sta_hi_q};
        if (addr == RA_MODE)   rdata = {{(CFG_DW-MODE_W){1'b0}}, mode_q};
        for (int k = 0; k < HASH_WORDS; k++)
            if (addr == RA_HASH0 + CFG_AW'(k)) rdata = hash_q[k];
    end

    assign station = {sta_hi_q, sta_lo_q};
    assign mode    = mode_q;
endmodule

// File: rtl/afp_decide.sv
module afp_decide
    import afp_pkg::*;
(
    input  logic [47:0]          dest,
    input  logic [47:0]          station,
    input  logic [HASH_BITS-1:0] table_bits,
    input  logic [MODE_W-1:0]    mode,
    input  logic [BIN_W-1:0]     bin,
    output logic                 accept
);
    logic is_group, is_bcast, hash_hit;

    assign is_group = dest[40];
    assign is_bcast = &dest;
    assign hash_hit = table_bits[bin];

    always_comb begin
        if (mode[MODE_PROMISC])  accept = 1'b1;
        else if (is_bcast)       accept = mode[MODE_BCAST];
        else if (is_group)       accept = mode[MODE_ALLMULTI] | hash_hit;
        else                     accept = (dest == station);
    end
endmodule

// File: rtl/addr_filter.sv
module addr_filter
    import afp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int HOLD_W = (ADDR_BYTES - 1) * 8;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    afp_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              acc_q;

    logic [47:0]          station;
    logic [HASH_BITS-1:0] table_bits;
    logic [MODE_W-1:0]    mode_q;
    logic [31:0]          crc_nxt;
    logic [47:0]          dest_full;
    logic                 acc_now;

    logic take_start, take_byte, take_last;

    assign take_start = rx_valid && rx_sof;
    assign take_byte  = rx_valid && !rx_sof && state_q == ST_COLLECT;
    assign take_last  = take_byte && cnt_q == LAST_IDX;
    assign dest_full  = {hold_q, rx_byte};

    afp_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .station(station),
        .table_bits(table_bits), .mode(mode_q)
    );

    afp_crc_be #(.CW(32), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .restart(take_start),
        .step(take_start || take_byte), .data(rx_byte), .crc_nxt(crc_nxt)
    );

    afp_decide u_decide (
        .dest(dest_full), .station(station), .table_bits(table_bits),
        .mode(mode_q), .bin(crc_nxt[31:26]), .accept(acc_now)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_start) state_d = ST_COLLECT;
            ST_COLLECT: if (take_start)     state_d = ST_COLLECT;
                        else if (take_last) state_d = ST_DONE;
            ST_DONE:    if (take_start) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            acc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                cnt_q  <= CNT_W'(1);
                hold_q <= {{(HOLD_W-8){1'b0}}, rx_byte};
            end else if (take_byte) begin
                cnt_q  <= cnt_q + CNT_W'(1);
                hold_q <= {hold_q[HOLD_W-9:0], rx_byte};
            end
            if (take_last) acc_q <= acc_now;
        end
    end

    // outputs
    always_comb begin
        dec_valid  = (state_q == ST_DONE);
        dec_accept = dec_valid && acc_q;
    end
endmodule

// File: rtl/addr_filter_sva.sv
module addr_filter_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_sof,
    input logic       rx_valid,
    input logic [2:0] mode_q,
    input logic       dec_valid,
    input logic       dec_accept
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !dec_valid && !dec_accept);                          // R1

    AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) && $past(mode_q[0]) |-> dec_accept);           // R7

    AST_RISE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(rx_valid) && !$past(rx_sof));        // R8

    AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !(rx_valid && rx_sof) |=> dec_valid && $stable(dec_accept)); // R9

    AST_SOF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_sof |=> !dec_valid);                             // R9

    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);                                      // R8
endmodule

bind addr_filter addr_filter_sva u_sva (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .mode_q(mode_q), .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/addr_filter_test.sv
module addr_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [47:0] STA   = 48'h00_1B_2C_3D_4E_5F;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_sof(rx_sof),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .dec_valid(dec_valid),
        .dec_accept(dec_accept)
    );

    task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] by = a[47-8*k -: 8];
            for (int b = 0; b < 8; b++) begin
                logic fb = c[31] ^ by[b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // sends six bytes; gap idle cycles between bytes; leaves us at the
    // negedge after the sixth byte's capture edge
    task automatic send(input logic [47:0] a, input int gap);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = a[47-8*k -: 8];
            if (gap > 0 && k < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_sof = 1'b0;
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic expect_dec(input logic exp, input string tag);
        chk(dec_valid === 1'b1, {tag, " valid"}, {47'b0, dec_valid}, 48'd1);
        chk(dec_accept === exp, {tag, " accept"}, {47'b0, dec_accept}, {47'b0, exp});
    endtask

    function automatic logic [47:0] find_group(input logic want_hi);
        for (int i = 0; i < 256; i++) begin
            logic [47:0] a = {24'h01_00_5E, 16'h0000, 8'(i)};
            if (ref_crc(a)[31] == want_hi) return a;
        end
        return 48'h01_00_5E_00_00_00;
    endfunction

    task automatic t_reset;
        chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R1 outputs", {46'b0, dec_valid, dec_accept}, 48'd0);
        for (int r = 0; r < 5; r++) begin
            @(negedge clk); cfg_addr = 3'(r); #1;
            chk(cfg_rdata === 32'd0, "R1 regs", {16'b0, cfg_rdata}, 48'd0);
        end
    endtask

    task automatic t_regs;
        wr(3'd1, 32'hDEAD_001B);
        @(negedge clk); cfg_addr = 3'd1; #1;
        chk(cfg_rdata === 32'h0000_001B, "R2 sta_hi", {16'b0, cfg_rdata}, 48'h1B);
        wr(3'd2, 32'hFFFF_FFF8);
        @(negedge clk); cfg_addr = 3'd2; #1;
        chk(cfg_rdata === 32'd0, "R2 mode width", {16'b0, cfg_rdata}, 48'd0);
        wr(3'd0, STA[31:0]); wr(3'd1, {16'b0, STA[47:32]});
        @(negedge clk); cfg_addr = 3'd0; #1;
        chk(cfg_rdata === STA[31:0], "R2 sta_lo", {16'b0, cfg_rdata}, {16'b0, STA[31:0]});
    endtask

    task automatic t_unicast;
        send(STA, 0);
        expect_dec(1'b1, "R3 match");
        send(STA ^ 48'h00_00_00_00_01_00, 0);
        expect_dec(1'b0, "R3 byte4 miss");
        send(STA ^ 48'h00_01_00_00_00_00, 0);
        expect_dec(1'b0, "R3 byte1 miss");
    endtask

    task automatic t_bcast;
        wr(3'd2, 32'h2);                     // all-multi only
        send(BCAST, 0);
        expect_dec(1'b0, "R4 bcast off");
        wr(3'd2, 32'h4);
        send(BCAST, 0);
        expect_dec(1'b1, "R4 bcast on");
        wr(3'd2, 32'h0);
    endtask

    task automatic t_hash;
        logic [47:0] alo = find_group(1'b0);
        logic [47:0] ahi = find_group(1'b1);
        logic [31:0] clo = ref_crc(alo);
        logic [31:0] chi = ref_crc(ahi);
        wr(3'd3, 32'd1 << clo[30:26]);
        wr(3'd4, 32'd0);
        send(alo, 0);
        expect_dec(1'b1, "R5 lower word hit");
        send(ahi, 0);
        expect_dec(1'b0, "R5 upper word empty");
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd1 << chi[30:26]);
        send(ahi, 0);
        expect_dec(1'b1, "R5 upper word hit");
        wr(3'd4, ~(32'd1 << chi[30:26]));
        wr(3'd3, ~(32'd1 << clo[30:26]));
        send(ahi, 0);
        expect_dec(1'b0, "R5 upper bin miss");
        send(alo, 0);
        expect_dec(1'b0, "R5 lower bin miss");
        wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    endtask

    task automatic t_allmulti;
        wr(3'd2, 32'h2);
        send(48'h33_33_00_00_00_01, 0);
        expect_dec(1'b1, "R6 allmulti group");
        send(48'h02_00_00_00_00_01, 0);
        expect_dec(1'b0, "R6 unicast unaffected");
        wr(3'd2, 32'h0);
    endtask

    task automatic t_promisc;
        wr(3'd2, 32'h1);
        send(48'h02_AA_BB_CC_DD_EE, 0);
        expect_dec(1'b1, "R7 promisc unicast");
        send(BCAST, 0);
        expect_dec(1'b1, "R7 promisc bcast");
        wr(3'd2, 32'h0);
    endtask

    task automatic t_timing;
        // valid must not be up before the sixth byte is taken
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = STA[47:40];
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            rx_sof = 1'b0; rx_byte = STA[47-8*k -: 8];
            if (k == 5)
                chk(dec_valid === 1'b0, "R8 early valid", {47'b0, dec_valid}, 48'd0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        expect_dec(1'b1, "R8 one cycle after");
        send(STA, 3);
        expect_dec(1'b1, "R8 gapped bytes");
    endtask

    task automatic t_hold_restart;
        send(STA, 0);
        wr(3'd1, 32'h0);                     // break station match after decision
        wr(3'd2, 32'h0);
        expect_dec(1'b1, "R9 held over writes");
        wr(3'd1, {16'b0, STA[47:32]});
        // restart midway: partial foreign address then a full station address
        @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'h02;
        @(negedge clk); rx_sof = 1'b0; rx_byte = 8'h99;
        chk(dec_valid === 1'b0, "R9 sof drops valid", {47'b0, dec_valid}, 48'd0);
        @(negedge clk); rx_valid = 1'b0;
        send(STA, 0);
        expect_dec(1'b1, "R9 restart");
    endtask

    task automatic t_stray;
        // in DONE with a reject, stray bytes must not alter anything
        send(48'h02_00_00_00_00_07, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = STA[47-8*(k%6) -: 8];
        end
        @(negedge clk); rx_valid = 1'b0;
        expect_dec(1'b0, "R10 stray bytes");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_regs();
                t_unicast();
                t_bcast();
                t_hash();
                t_allmulti();
                t_promisc();
                t_timing();
                t_hold_restart();
                t_stray();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule